// File: doc/BRIEF.md
# Two-Level Burst Beat Sequencer

This block sits inside a master-to-slave interconnect. It takes a single burst request and expands it into a series of 32-bit bus beats. A request carries three things: a start address, a segment size in bytes, and a repeat count. The block cuts the segment into word beats, moving the address forward by one word on each beat. It then plays the segment as many times as the repeat count asks. Between two segments it adds an extra address skip equal to the repeat count.

Each beat leaves on a valid/ready handshake. The beat carries its address, its position inside the segment (counting from 1), and two marker flags. One flag marks the end of a segment and the other marks the end of the burst. After the closing beat is taken, a one-cycle done pulse follows. A request with illegal fields produces no beats and returns a one-cycle error pulse instead. The block carries no data payload.

Top module: `burst_beat_seq`

## Requirements
- R1: A start request with legal fields, seen while the block is idle, makes the first beat appear in the next cycle. That beat has valid high, busy high, address equal to the start address, and beat index 1.
- R2: Every segment holds size/4 beats, and their beat indices run 1, 2, …, size/4. A request with size 16 and length 2 therefore gives indices 1,2,3,4,1,2,3,4.
- R3: Within a segment, each accepted beat is followed by a beat whose address is 4 higher.
- R4: After the closing beat of a segment is accepted, the next segment begins at that beat's address plus 4 plus the length value.
- R5: The segment is played length times, so the burst is length × size/4 beats long.
- R6: The segment-end flag is high only on the closing beat of each segment. The burst-end flag is high only on the final beat of the burst.
- R7: A beat is consumed only at a clock edge where valid and ready are both high. While ready is low, valid, address, index and both flags stay unchanged.
- R8: Done is high for exactly one cycle, the cycle after the final beat is accepted. In that cycle valid and busy are already low.
- R9: A request is illegal if size is 0, size is not a multiple of 4, size is above 128, length is 0, or length is above 16. An illegal request raises the error output for one cycle, in the next cycle, and no beat is issued.
- R10: While a burst is running, a start request has no effect on the beat sequence.
- R11: A synchronous active-high reset, even in the middle of a burst, returns the block to idle. After reset, valid, busy, done and error are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe |
| start_addr_i | input | 32 | Start address of the burst |
| size_i | input | 8 | Segment size in bytes |
| length_i | input | 5 | Number of segment repetitions |
| busy_o | output | 1 | Burst in progress |
| err_o | output | 1 | One-cycle pulse when a request is rejected |
| beat_valid_o | output | 1 | A beat is being presented |
| beat_ready_i | input | 1 | Downstream accepts the beat |
| beat_addr_o | output | 32 | Address of the current beat |
| beat_idx_o | output | 6 | Position of the beat in its segment, counting from 1 |
| seg_last_o | output | 1 | Closing beat of a segment |
| burst_last_o | output | 1 | Final beat of the burst |
| done_o | output | 1 | One-cycle pulse after the final beat is accepted |

## Verification
The timing the bench expects is as follows:

- The first beat and the error pulse both appear one cycle after the request edge.
- Each accepted beat changes the outputs one cycle after the edge that accepted it.
- Done appears one cycle after the final accept.

The reference model builds the full expected beat list from the request using plain nested loops. At every falling edge it compares the presented beat with the head of that list. It pops the head only when ready was high at the edge just passed. Stall cycles therefore become checks that the outputs held steady. The bench also injects stray start requests during bursts, and asserts reset in the middle of a burst.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bbs_state_e;
endpackage

// File: rtl/bbs_req_check.sv
module bbs_req_check #(
    parameter int SIZE_W     = 8,
    parameter int LEN_W      = 5,
    parameter int BEAT_W     = 6,
    parameter int WORD_BYTES = 4,
    parameter int MAX_SIZE   = 128,
    parameter int MAX_LEN    = 16
) (
    input  logic [SIZE_W-1:0] size_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              ok_o,
    output logic [BEAT_W-1:0] beats_o
);
    localparam int SHIFT = $clog2(WORD_BYTES);

    logic size_ok;
    logic len_ok;

    always_comb begin
        size_ok = (size_i != '0)
                  && (size_i[SHIFT-1:0] == '0)
                  && (int'(size_i) <= MAX_SIZE);
        len_ok  = (len_i != '0) && (int'(len_i) <= MAX_LEN);
        ok_o    = size_ok && len_ok;
        beats_o = BEAT_W'(size_i >> SHIFT);
    end
endmodule

// File: rtl/bbs_step_ctr.sv
module bbs_step_ctr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] value_o,
    output logic         last_o
);
    logic [W-1:0] value_d, value_q;

    always_comb begin
        value_d = value_q;
        if (load_i) begin
            value_d = W'(1);
        end else if (step_i) begin
            value_d = value_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) value_q <= '0;
        else     value_q <= value_d;
    end

    assign value_o = value_q;
    assign last_o  = (value_q == limit_i);

    // R2: the counter is never stepped past its limit
    a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |-> (value_q != limit_i));
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int MAX_SIZE   = 128,
    parameter int MAX_LEN    = 16,
    parameter int SIZE_W     = $clog2(MAX_SIZE + 1),
    parameter int LEN_W      = $clog2(MAX_LEN + 1),
    parameter int BEAT_W     = $clog2(MAX_SIZE / WORD_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [LEN_W-1:0]  length_i,
    output logic              busy_o,
    output logic              err_o,
    output logic              beat_valid_o,
    input  logic              beat_ready_i,
    output logic [ADDR_W-1:0] beat_addr_o,
    output logic [BEAT_W-1:0] beat_idx_o,
    output logic              seg_last_o,
    output logic              burst_last_o,
    output logic              done_o
);
    import bbs_pkg::*;

    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        bbs_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] bps;
        logic [LEN_W-1:0]  len;
        logic              done;
        logic              err;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    logic              req_ok;
    logic [BEAT_W-1:0] req_beats;
    logic              accept;
    logic              fire;
    logic              beat_load, beat_step, beat_last;
    logic              seg_load, seg_step, seg_last;
    logic [BEAT_W-1:0] beat_val;
    logic [LEN_W-1:0]  seg_val;

    bbs_req_check #(
        .SIZE_W(SIZE_W), .LEN_W(LEN_W), .BEAT_W(BEAT_W),
        .WORD_BYTES(WORD_BYTES), .MAX_SIZE(MAX_SIZE), .MAX_LEN(MAX_LEN)
    ) u_check (
        .size_i (size_i),
        .len_i  (length_i),
        .ok_o   (req_ok),
        .beats_o(req_beats)
    );

    bbs_step_ctr #(.W(BEAT_W)) u_beat_ctr (
        .clk    (clk),
        .rst    (rst),
        .load_i (beat_load),
        .step_i (beat_step),
        .limit_i(r_q.bps),
        .value_o(beat_val),
        .last_o (beat_last)
    );

    bbs_step_ctr #(.W(LEN_W)) u_seg_ctr (
        .clk    (clk),
        .rst    (rst),
        .load_i (seg_load),
        .step_i (seg_step),
        .limit_i(r_q.len),
        .value_o(seg_val),
        .last_o (seg_last)
    );

    always_comb begin
        accept    = (r_q.st == ST_IDLE) && start_i;
        fire      = (r_q.st == ST_RUN) && beat_ready_i;
        beat_load = (accept && req_ok) || (fire && beat_last);
        beat_step = fire && !beat_last;
        seg_load  = accept && req_ok;
        seg_step  = fire && beat_last && !seg_last;

        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        if (accept) begin
            if (req_ok) begin
                r_d.st   = ST_RUN;
                r_d.addr = start_addr_i;
                r_d.bps  = req_beats;
                r_d.len  = length_i;
            end else begin
                r_d.err = 1'b1;
            end
        end else if (fire) begin
            if (!beat_last) begin
                r_d.addr = r_q.addr + WORD_STEP;
            end else if (!seg_last) begin
                r_d.addr = r_q.addr + WORD_STEP + ADDR_W'(r_q.len);
            end else begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, addr: '0, bps: '0, len: '0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign beat_valid_o = (r_q.st == ST_RUN);
    assign busy_o       = (r_q.st == ST_RUN);
    assign beat_addr_o  = r_q.addr;
    assign beat_idx_o   = beat_val;
    assign seg_last_o   = beat_valid_o && beat_last;
    assign burst_last_o = beat_valid_o && beat_last && seg_last;
    assign done_o       = r_q.done;
    assign err_o        = r_q.err;

    // R7: a stalled beat holds every field
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(beat_addr_o)
            && $stable(beat_idx_o) && $stable(seg_last_o) && $stable(burst_last_o)));

    // R3: in-segment address step of one word
    a_r3_word_step: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && beat_ready_i && !seg_last_o)
            |=> (beat_addr_o == $past(beat_addr_o) + WORD_STEP));

    // R8: done follows the final accept and the beat stream stops
    a_r8_done_after_final: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && beat_ready_i && burst_last_o) |=> (done_o && !beat_valid_o && !busy_o));

    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: rejected request yields error and no beat
    a_r9_reject: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && !req_ok) |=> (err_o && !beat_valid_o));

    // R6: burst end marks a segment end as well
    a_r6_burst_in_seg: assert property (@(posedge clk) disable iff (rst)
        burst_last_o |-> seg_last_o);
endmodule

// File: tb/tb_burst_beat_seq.sv
module tb_burst_beat_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] start_addr_i;
    logic [7:0]  size_i;
    logic [4:0]  length_i;
    logic        busy_o, err_o, beat_valid_o, beat_ready_i;
    logic [31:0] beat_addr_o;
    logic [5:0]  beat_idx_o;
    logic        seg_last_o, burst_last_o, done_o;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [31:0] addr;
        int          idx;
        bit          sl;
        bit          bl;
    } beat_t;

    beat_t exp_q[$];

    always #5 clk = ~clk;

    burst_beat_seq dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .size_i(size_i), .length_i(length_i), .busy_o(busy_o), .err_o(err_o),
        .beat_valid_o(beat_valid_o), .beat_ready_i(beat_ready_i),
        .beat_addr_o(beat_addr_o), .beat_idx_o(beat_idx_o),
        .seg_last_o(seg_last_o), .burst_last_o(burst_last_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, {28'd0, beat_valid_o, busy_o, done_o, err_o}, 32'd0);
    endtask

    task automatic build(input logic [31:0] a0, input int sz, input int ln);
        logic [31:0] a = a0;
        int nb = sz / 4;
        exp_q.delete();
        for (int s = 0; s < ln; s++) begin
            for (int b = 1; b <= nb; b++) begin
                exp_q.push_back('{a, b, b == nb, (b == nb) && (s == ln - 1)});
                a = a + 32'd4;
            end
            a = a + 32'(ln);
        end
    endtask

    // Legal burst: stall_mod 0 means always ready; inject drives stray starts (R10)
    task automatic run_burst(input logic [31:0] a0, input int sz, input int ln,
                             input int stall_mod, input bit inject);
        int cyc = 0;
        bit rdy;
        build(a0, sz, ln);
        start_i = 1'b1; start_addr_i = a0; size_i = 8'(sz); length_i = 5'(ln);
        @(negedge clk);
        start_i = 1'b0;
        check("R1 valid", {31'd0, beat_valid_o}, 32'd1);
        check("R1 busy", {31'd0, busy_o}, 32'd1);
        check("R1 first addr", beat_addr_o, a0);
        check("R1 first idx", {26'd0, beat_idx_o}, 32'd1);
        while (exp_q.size() > 0) begin
            beat_t h = exp_q[0];
            check("R5 valid while beats remain", {31'd0, beat_valid_o}, 32'd1);
            check("R3 R4 addr", beat_addr_o, h.addr);
            check("R2 idx", {26'd0, beat_idx_o}, 32'(h.idx));
            check("R6 seg_last", {31'd0, seg_last_o}, {31'd0, h.sl});
            check("R6 burst_last", {31'd0, burst_last_o}, {31'd0, h.bl});
            check("R8 no early done", {31'd0, done_o}, 32'd0);
            rdy = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
            beat_ready_i = rdy;
            if (inject && (cyc % 2 == 1)) begin
                start_i = 1'b1; start_addr_i = 32'hDEAD_0000; size_i = 8'd4; length_i = 5'd1;
            end else begin
                start_i = 1'b0;
            end
            cyc++;
            @(negedge clk);
            if (rdy) void'(exp_q.pop_front());
        end
        start_i = 1'b0;
        beat_ready_i = 1'b0;
        check("R8 done pulse", {31'd0, done_o}, 32'd1);
        check("R8 valid low at done", {31'd0, beat_valid_o}, 32'd0);
        check("R8 busy low at done", {31'd0, busy_o}, 32'd0);
        @(negedge clk);
        check("R8 done one cycle", {31'd0, done_o}, 32'd0);
        check("R10 R5 no extra beat", {31'd0, beat_valid_o}, 32'd0);
    endtask

    task automatic run_bad(input int sz, input int ln, input string what);
        start_i = 1'b1; start_addr_i = 32'h0000_7000; size_i = 8'(sz); length_i = 5'(ln);
        @(negedge clk);
        start_i = 1'b0;
        check({"R9 err ", what}, {31'd0, err_o}, 32'd1);
        check({"R9 no beat ", what}, {30'd0, beat_valid_o, busy_o}, 32'd0);
        @(negedge clk);
        check({"R9 err one cycle ", what}, {31'd0, err_o}, 32'd0);
        check({"R9 still no beat ", what}, {31'd0, beat_valid_o}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; start_addr_i = '0; size_i = '0; length_i = '0;
        beat_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R11 reset state");
        rst = 1'b0;
        @(negedge clk);

        run_burst(32'h0000_1000, 16, 2, 0, 1'b0);
        run_burst(32'h0000_3004, 4, 1, 0, 1'b0);
        run_burst(32'h0000_0400, 8, 3, 2, 1'b1);
        run_burst(32'h0000_2000, 128, 16, 3, 1'b1);
        run_burst(32'hFFFF_FFF0, 12, 5, 4, 1'b0);

        run_bad(0, 2, "size zero");
        run_bad(6, 2, "size not word multiple");
        run_bad(132, 1, "size too big");
        run_bad(16, 0, "length zero");
        run_bad(16, 17, "length too big");

        // R11: reset in the middle of a burst
        start_i = 1'b1; start_addr_i = 32'h0000_5000; size_i = 8'd16; length_i = 5'd4;
        beat_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R11 mid-burst reset");
        rst = 1'b0;
        beat_ready_i = 1'b0;
        @(negedge clk);
        check_idle("R11 stays idle after reset");
        run_burst(32'h0000_6000, 8, 2, 0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule